// File: doc/BRIEF.md
# Line Readout Sequencer with Pixel Counter

This block paces the readout of an image array one row at a time after an exposure. A host gives a frame-start strobe, which clears the row count, and a row-advance strobe for each line. When a row advance is taken, the block runs a row-blanking phase. Blanking has two ordered parts. First a signal-level sample strobe is asserted, then a reset-level sample strobe, as needed for double sampling. Next the block issues a one-cycle line sync, raises pixel-valid and steps a pixel index until it equals a programmable last-pixel value.

A programmable granularity divider sets the blanking length. It produces a granulated clock enable once every `gran_div_i + 1` system clocks, and each blanking part lasts a fixed number of these granulated periods. Holding the row-advance strobe high keeps the sequencer suspended, and the line starts once the strobe drops. If a row advance arrives while a line is active, it is remembered and served as soon as that line ends.

Top module: `line_readout_seq`

## Requirements
- R1: After reset, `samp_sig_o`, `samp_rst_o`, `line_sync_o` and `pix_valid_o` are low, and `pix_idx_o` and `row_idx_o` are zero.
- R2: A frame-start pulse held high for at least FS_MIN (default 3) consecutive clocks sets `row_idx_o` to zero in the clock on which its third high cycle is sampled. A pulse that is shorter leaves `row_idx_o` unchanged.
- R3: While `row_adv_i` is high the sequencer starts no line. The line starts on the clock edge after the first low sample of `row_adv_i` that follows a high one, and `samp_sig_o` is visible one cycle later.
- R4: `samp_sig_o` stays high for exactly SIG_PER×(D+1) clocks, where D is `gran_div_i` and SIG_PER defaults to 2.
- R5: `samp_rst_o` rises in the clock right after `samp_sig_o` falls and stays high for RST_PER×(D+1) clocks, with RST_PER defaulting to 2. The two strobes are never high together.
- R6: With D = `gran_div_i`, the total blanking length is (SIG_PER+RST_PER)×(D+1) clocks, so the granulated enable fires once every D+1 clocks, counted from the start of the line.
- R7: `pix_valid_o` rises in the clock right after `samp_rst_o` falls. `line_sync_o` is high for exactly that first valid clock.
- R8: While `pix_valid_o` is high, `pix_idx_o` runs 0, 1, … up to N = `pix_count_i`, so the line has N+1 valid clocks. `pix_valid_o` falls after the clock in which the index equals N, and `pix_idx_o` reads zero outside readout.
- R9: `row_idx_o` goes up by one each time a line starts (the count wraps modulo 2^ROW_W).
- R10: A row advance received during blanking or readout is kept pending. The next line's `samp_sig_o` then rises two clocks after the last valid pixel, as long as `row_adv_i` is low by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame-start strobe from host |
| row_adv_i | input | 1 | Row-advance strobe from host |
| gran_div_i | input | GRAN_W | Granularity divider D; granulated period is D+1 clocks |
| pix_count_i | input | PIX_W | Last pixel index N of a line |
| samp_sig_o | output | 1 | Signal-level sample strobe |
| samp_rst_o | output | 1 | Reset-level sample strobe |
| line_sync_o | output | 1 | One-cycle pulse at readout start |
| pix_valid_o | output | 1 | High while pixels are read out |
| pix_idx_o | output | PIX_W | Current pixel index |
| row_idx_o | output | ROW_W | Count of lines started since frame start |

## Verification
A wrong phase counter or a wrong granulated-enable counter shows up as a sample strobe that is too short or too long. This appears at the ports in the first line after the fault, within (SIG_PER+RST_PER)×(D+1) clocks. A fault in the pixel counter changes the index sequence on the next valid clock, or moves the fall of pixel-valid. A lost pending flag or a corrupted row counter shows as a line that never starts, or as a row index off by one, once the current line ends. The bench sweeps every granularity of a small configuration against several pixel counts and compares each output in every cycle with positions computed arithmetically.

// File: rtl/line_seq_pkg.sv
package line_seq_pkg;
  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_SSIG  = 2'd1,
    LS_SRST  = 2'd2,
    LS_READ  = 2'd3
  } ls_state_t;
endpackage

// File: rtl/lrs_fs_filter.sv
module lrs_fs_filter #(
  parameter int FS_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start_i,
  output logic fs_acc_o
);
  localparam int CW = $clog2(FS_MIN + 1);
  localparam logic [CW-1:0] SAT = CW'(FS_MIN);

  logic [CW-1:0] run_q, run_n;

  // accept on the FS_MIN-th consecutive high sample, once per pulse
  assign fs_acc_o = frame_start_i && (run_q == CW'(FS_MIN - 1));

  always_comb begin
    if (!frame_start_i)    run_n = '0;
    else if (run_q == SAT) run_n = run_q;
    else                   run_n = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_n;
  end

  AST_FS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_acc_o |=> !fs_acc_o); // R2
  AST_FS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fs_acc_o |-> $past(frame_start_i)); // R2
endmodule

// File: rtl/lrs_gran_ce.sv
module lrs_gran_ce #(
  parameter int GRAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic [GRAN_W-1:0] div_i,
  output logic              ce_o
);
  logic [GRAN_W-1:0] cnt_q, cnt_n;

  assign ce_o = (cnt_q == div_i);

  always_comb begin
    if (restart_i || ce_o) cnt_n = '0;
    else                   cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_CE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_o && !restart_i && div_i != '0 && $stable(div_i)) |=> !ce_o); // R6
endmodule

// File: rtl/lrs_line_fsm.sv
module lrs_line_fsm
  import line_seq_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int ROW_W   = 11,
  parameter int SIG_PER = 2,
  parameter int RST_PER = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_adv_i,
  input  logic             fs_acc_i,
  input  logic             ce_i,
  input  logic [PIX_W-1:0] pix_count_i,
  output logic             restart_o,
  output logic             samp_sig_o,
  output logic             samp_rst_o,
  output logic             line_sync_o,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_idx_o,
  output logic [ROW_W-1:0] row_idx_o
);
  localparam int PH_MAX = (SIG_PER > RST_PER) ? SIG_PER : RST_PER;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] SIG_LAST = PH_W'(SIG_PER - 1);
  localparam logic [PH_W-1:0] RST_LAST = PH_W'(RST_PER - 1);

  ls_state_t        st_q, st_n;
  logic [PH_W-1:0]  ph_q, ph_n;
  logic [PIX_W-1:0] pix_q, pix_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic             armed_q, armed_n;

  always_comb begin
    st_n      = st_q;
    ph_n      = ph_q;
    pix_n     = pix_q;
    row_n     = row_q;
    armed_n   = armed_q | row_adv_i;
    restart_o = 1'b0;
    unique case (st_q)
      LS_IDLE: begin
        if (armed_q && !row_adv_i) begin
          st_n      = LS_SSIG;
          ph_n      = '0;
          restart_o = 1'b1;
          armed_n   = 1'b0;
          row_n     = row_q + 1'b1;
        end
      end
      LS_SSIG: begin
        if (ce_i) begin
          if (ph_q == SIG_LAST) begin
            st_n = LS_SRST;
            ph_n = '0;
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
      end
      LS_SRST: begin
        if (ce_i) begin
          if (ph_q == RST_LAST) begin
            st_n  = LS_READ;
            ph_n  = '0;
            pix_n = '0;
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
      end
      LS_READ: begin
        if (pix_q == pix_count_i) begin
          st_n  = LS_IDLE;
          pix_n = '0;
        end else begin
          pix_n = pix_q + 1'b1;
        end
      end
      default: st_n = LS_IDLE;
    endcase
    if (fs_acc_i) row_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LS_IDLE;
      ph_q    <= '0;
      pix_q   <= '0;
      row_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      ph_q    <= ph_n;
      pix_q   <= pix_n;
      row_q   <= row_n;
      armed_q <= armed_n;
    end
  end

  assign samp_sig_o  = (st_q == LS_SSIG);
  assign samp_rst_o  = (st_q == LS_SRST);
  assign pix_valid_o = (st_q == LS_READ);
  assign line_sync_o = (st_q == LS_READ) && (pix_q == '0);
  assign pix_idx_o   = pix_q;
  assign row_idx_o   = row_q;

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_IDLE && row_adv_i) |=> st_q == LS_IDLE); // R3
  AST_RST_AFTER_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_rst_o) |-> $past(samp_sig_o)); // R5
  AST_VALID_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid_o) |-> ($past(samp_rst_o) && line_sync_o)); // R7
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && $past(pix_valid_o)) |-> pix_idx_o == $past(pix_idx_o) + 1'b1); // R8
  AST_PIX_END: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && pix_idx_o == pix_count_i) |=> !pix_valid_o); // R8
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(samp_sig_o) && !$past(fs_acc_i)) |-> row_idx_o == $past(row_idx_o) + 1'b1); // R9
endmodule

// File: rtl/line_readout_seq.sv
module line_readout_seq #(
  parameter int PIX_W   = 12,
  parameter int ROW_W   = 11,
  parameter int GRAN_W  = 4,
  parameter int FS_MIN  = 3,
  parameter int SIG_PER = 2,
  parameter int RST_PER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              row_adv_i,
  input  logic [GRAN_W-1:0] gran_div_i,
  input  logic [PIX_W-1:0]  pix_count_i,
  output logic              samp_sig_o,
  output logic              samp_rst_o,
  output logic              line_sync_o,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_idx_o,
  output logic [ROW_W-1:0]  row_idx_o
);
  logic fs_acc;
  logic gran_ce;
  logic gran_restart;

  lrs_fs_filter #(.FS_MIN(FS_MIN)) fs_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .fs_acc_o      (fs_acc)
  );

  lrs_gran_ce #(.GRAN_W(GRAN_W)) gce_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (gran_restart),
    .div_i     (gran_div_i),
    .ce_o      (gran_ce)
  );

  lrs_line_fsm #(
    .PIX_W   (PIX_W),
    .ROW_W   (ROW_W),
    .SIG_PER (SIG_PER),
    .RST_PER (RST_PER)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_adv_i   (row_adv_i),
    .fs_acc_i    (fs_acc),
    .ce_i        (gran_ce),
    .pix_count_i (pix_count_i),
    .restart_o   (gran_restart),
    .samp_sig_o  (samp_sig_o),
    .samp_rst_o  (samp_rst_o),
    .line_sync_o (line_sync_o),
    .pix_valid_o (pix_valid_o),
    .pix_idx_o   (pix_idx_o),
    .row_idx_o   (row_idx_o)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({samp_sig_o, samp_rst_o, pix_valid_o}) <= 1); // R5
endmodule

// File: tb/line_readout_seq_tb.sv
module line_readout_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 4;
  localparam int ROW_W  = 5;
  localparam int GRAN_W = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_start_i;
  logic              row_adv_i;
  logic [GRAN_W-1:0] gran_div_i;
  logic [PIX_W-1:0]  pix_count_i;
  logic              samp_sig_o, samp_rst_o, line_sync_o, pix_valid_o;
  logic [PIX_W-1:0]  pix_idx_o;
  logic [ROW_W-1:0]  row_idx_o;

  int n_chk  = 0;
  int n_fail = 0;
  int row_exp = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_readout_seq #(.PIX_W(PIX_W), .ROW_W(ROW_W), .GRAN_W(GRAN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .row_adv_i(row_adv_i),
    .gran_div_i(gran_div_i), .pix_count_i(pix_count_i), .samp_sig_o(samp_sig_o),
    .samp_rst_o(samp_rst_o), .line_sync_o(line_sync_o), .pix_valid_o(pix_valid_o),
    .pix_idx_o(pix_idx_o), .row_idx_o(row_idx_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare all outputs at line-relative sample k against arithmetic positions
  task automatic chk_line_sample(input int k, input int d, input int n);
    int sig_end = 2 * (d + 1);
    int rst_end = 4 * (d + 1);
    int v0 = rst_end + 1;
    bit e_sig = (k >= 1 && k <= sig_end);
    bit e_rst = (k > sig_end && k <= rst_end);
    bit e_val = (k >= v0 && k <= v0 + n);
    chk("R4", "samp_sig", int'(samp_sig_o), int'(e_sig));
    chk("R5", "samp_rst", int'(samp_rst_o), int'(e_rst));
    chk("R7", "pix_valid", int'(pix_valid_o), int'(e_val));
    chk("R7", "line_sync", int'(line_sync_o), int'(k == v0));
    chk("R8", "pix_idx", int'(pix_idx_o), e_val ? (k - v0) : 0);
  endtask

  // one line; optional row advance during the line to test pending service
  task automatic run_line(input int d, input int n, input bit pend);
    int kend = 4 * (d + 1) + 1 + n;
    gran_div_i  = GRAN_W'(d);
    pix_count_i = PIX_W'(n);
    row_adv_i   = 1'b1;
    @(negedge clk);
    row_adv_i = 1'b0;
    row_exp = (row_exp + 1) % (1 << ROW_W);
    for (int k = 1; k <= kend + 1; k++) begin
      @(negedge clk);
      row_adv_i = 1'b0;
      chk_line_sample(k, d, n);
      if (pend && k == kend - 1) row_adv_i = 1'b1;
    end
    chk("R9", "row_idx", int'(row_idx_o), row_exp);
    if (pend) begin
      @(negedge clk);
      row_exp = (row_exp + 1) % (1 << ROW_W);
      chk("R10", "pending samp_sig", int'(samp_sig_o), 1);
      chk("R10", "pending row_idx", int'(row_idx_o), row_exp);
      for (int k = 2; k <= kend + 1; k++) begin
        @(negedge clk);
        chk_line_sample(k, d, n);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_start_i = 1'b0; row_adv_i = 1'b0;
    gran_div_i = '0; pix_count_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "samp_sig", int'(samp_sig_o), 0);
    chk("R1", "pix_valid", int'(pix_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "samp_rst", int'(samp_rst_o), 0);
    chk("R1", "line_sync", int'(line_sync_o), 0);
    chk("R1", "pix_idx", int'(pix_idx_o), 0);
    chk("R1", "row_idx", int'(row_idx_o), 0);

    // R4 R5 R6 R7 R8 R9: sweep every granularity against several pixel counts
    for (int d = 0; d < (1 << GRAN_W); d++)
      for (int n = 0; n < 6; n++)
        run_line(d, n, 1'b0);

    // R10: row advance during the line served right after it
    run_line(1, 2, 1'b1);
    run_line(0, 0, 1'b1);
    run_line(3, 5, 1'b1);

    // R3: suspended while the row-advance strobe is held
    gran_div_i = 2'd1; pix_count_i = 4'd3;
    row_adv_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R3", "suspended samp_sig", int'(samp_sig_o), 0);
      chk("R3", "suspended row_idx", int'(row_idx_o), row_exp);
    end
    row_adv_i = 1'b0;
    row_exp = (row_exp + 1) % (1 << ROW_W);
    for (int k = 1; k <= 4 * 2 + 1 + 3 + 1; k++) begin
      @(negedge clk);
      chk_line_sample(k, 1, 3);
    end
    chk("R3", "row after release", int'(row_idx_o), row_exp);

    // R2: short frame-start pulses ignored
    for (int w = 1; w < 3; w++) begin
      frame_start_i = 1'b1;
      repeat (w) @(negedge clk);
      frame_start_i = 1'b0;
      @(negedge clk);
      chk("R2", "short frame start", int'(row_idx_o), row_exp);
    end
    // R2: long enough pulse clears the row count
    frame_start_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "frame start accepted", int'(row_idx_o), 0);
    frame_start_i = 1'b0;
    row_exp = 0;
    run_line(2, 1, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule